// File: doc/BRIEF.md
# Lockstep Processing-Element Array with Mask Stack

The block is a one-dimensional row of small processing elements that all obey one instruction stream, issued at most one instruction per cycle by an external control unit. Each element holds a few private registers, an ALU and an inhibit (mask) bit. An element whose mask bit is set keeps its registers unchanged for any broadcast data operation. In the same cycle, each element can pass a register value to the element on its left or on its right.

Conditional vector code runs without branches. An IF instruction saves every element's mask on a per-element mask stack. Each element that is running then masks itself when the condition is false. The THEN instructions follow. ELSE inverts the mask, but only in the elements that were running when the IF arrived. The ELSE instructions follow, and ENDIF puts back the saved mask. Up to four conditionals can be nested. An "any active" output tells the control unit whether any element is running, so it can skip a branch in which no element would run.

The control unit fills and inspects element registers through a load port and a combinational read port. These two ports act on one element and one register at a time.

Top module: `simd_lane_array`

## Requirements
- R1: After a synchronous active-low reset, every register of every element reads 0, every mask is clear, no conditional level is open, and `any_active` is 1.
- R2: A load (`ld_en`=1) writes `ld_data` into register `ld_reg` of element `ld_pe` at the next edge, whatever that element's mask. The read port returns register `rd_reg` of element `rd_pe` combinationally. If a broadcast instruction writes the same register of the same element in the same cycle, the load value wins.
- R3: When `ins_valid`=1, every unmasked element runs the opcode in the same cycle, and the result is visible after the next edge. The opcodes are: 0 NOP; 1 rd=ra+rb; 2 rd=ra-rb; 3 rd=ra&rb; 4 rd=ra|rb; 5 rd=ra^rb; 6 rd=imm; 7 rd=ra+imm. All arithmetic wraps modulo 2^DATA_W. Opcodes 14 and 15 act as NOP.
- R4: An element whose mask is set does not change any register for a broadcast data or shift instruction.
- R5: IF (opcode 10 tests ra==rb; opcode 11 tests ra<rb, unsigned) pushes each element's mask. An unmasked element then sets its mask when the condition is false. An element that was already masked stays masked.
- R6: ELSE (opcode 12) inverts the mask only in elements that were unmasked when the innermost open IF arrived. The other elements stay masked.
- R7: ENDIF (opcode 13) restores each element's mask to its value before the innermost open IF. Four levels nest.
- R8: An IF issued while four levels are open is ignored entirely: no push and no mask change. ELSE or ENDIF issued with no level open is ignored.
- R9: `any_active` is 1 exactly when at least one element has its mask clear.
- R10: Opcode 8 (shift toward lower index) writes ra of element i+1 into rd of element i. Opcode 9 (shift toward higher index) writes ra of element i-1 into rd of element i. An end element with no source neighbour receives 0. All elements move together, using the values from before the instruction, and a masked receiver keeps its register. A masked element still supplies its value to its neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Broadcast instruction present this cycle |
| ins_op | input | 4 | Opcode |
| ins_rd | input | $clog2(NUM_REGS) | Destination register |
| ins_ra | input | $clog2(NUM_REGS) | First source register |
| ins_rb | input | $clog2(NUM_REGS) | Second source register |
| ins_imm | input | DATA_W | Immediate |
| ld_en | input | 1 | Load strobe |
| ld_pe | input | $clog2(NUM_PE) | Element selected for load |
| ld_reg | input | $clog2(NUM_REGS) | Register selected for load |
| ld_data | input | DATA_W | Load value |
| rd_pe | input | $clog2(NUM_PE) | Element selected for readback |
| rd_reg | input | $clog2(NUM_REGS) | Register selected for readback |
| rd_data | output | DATA_W | Readback value |
| any_active | output | 1 | At least one element unmasked |

## Verification
The assertions assume that all instruction fields are driven to known values while `ins_valid` is high. They also assume that the nesting counter is the only record of open levels, so an ENDIF or ELSE with no level open has to leave the counter at zero. The bench issues each instruction on the falling edge and drops it after the next rising edge. It deliberately sends a fifth IF while four levels are open, and an ELSE and an ENDIF while no level is open, so that the ignore rules are exercised and not merely avoided. Its random stream mixes every opcode, including the unused ones. A behavioural model applies the same nesting limits, so the model and the design remain comparable after over- and under-nesting.

// File: rtl/simd_pkg.sv
// Package: shared opcode encoding for the lockstep element array.
// Assumes a 4-bit opcode field; codes 14 and 15 are unused and act as NOP.
package simd_pkg;
    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_LDI   = 4'd6,
        OP_ADDI  = 4'd7,
        OP_SHL   = 4'd8,
        OP_SHR   = 4'd9,
        OP_IFEQ  = 4'd10,
        OP_IFLT  = 4'd11,
        OP_ELSE  = 4'd12,
        OP_ENDIF = 4'd13
    } simd_op_e;
endpackage

// File: rtl/simd_mask_ctl.sv
// Module: simd_mask_ctl
// Tracks how many conditional levels are open and qualifies the mask-stack
// operations (push, flip, pop) that are broadcast to every element.
// Assumes one instruction per cycle; over- and under-nested ops are dropped.
module simd_mask_ctl
    import simd_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ins_valid,
    input  logic [3:0] ins_op,
    output logic       push,
    output logic       flip,
    output logic       pop
);
    localparam int DW = $clog2(STACK_DEPTH + 1);

    logic [DW-1:0] depth;
    logic          is_if;
    logic          full;
    logic          empty;

    // Decode the mask-stack ops and gate them by the nesting limits.
    always_comb begin
        is_if = (ins_op == OP_IFEQ) || (ins_op == OP_IFLT);
        full  = (depth == DW'(STACK_DEPTH));
        empty = (depth == '0);
        push  = ins_valid && is_if && !full;
        flip  = ins_valid && (ins_op == OP_ELSE) && !empty;
        pop   = ins_valid && (ins_op == OP_ENDIF) && !empty;
    end

    // Count open conditional levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (push) begin
            depth <= depth + 1'b1;
        end else if (pop) begin
            depth <= depth - 1'b1;
        end
    end

    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(STACK_DEPTH)); // R8
    AST_FULL_IF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && is_if && depth == DW'(STACK_DEPTH)) |=> depth == DW'(STACK_DEPTH)); // R8
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_op == OP_ENDIF && depth == '0) |=> depth == '0); // R8
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> depth == $past(depth) - 1'b1); // R7
endmodule

// File: rtl/simd_pe.sv
// Module: simd_pe
// One processing element: private register file, ALU, mask bit and a
// per-element mask stack. Executes the broadcast instruction when unmasked.
// Assumes push/flip/pop arrive already qualified by simd_mask_ctl, and that
// hi_in / lo_in carry the neighbours' ra values (zero at array ends).
module simd_pe
    import simd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_REGS    = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_valid,
    input  logic [3:0]                  ins_op,
    input  logic [$clog2(NUM_REGS)-1:0] ins_rd,
    input  logic [$clog2(NUM_REGS)-1:0] ins_ra,
    input  logic [$clog2(NUM_REGS)-1:0] ins_rb,
    input  logic [DATA_W-1:0]           ins_imm,
    input  logic                        push,
    input  logic                        flip,
    input  logic                        pop,
    input  logic [DATA_W-1:0]           hi_in,
    input  logic [DATA_W-1:0]           lo_in,
    input  logic                        ld_hit,
    input  logic [$clog2(NUM_REGS)-1:0] ld_reg,
    input  logic [DATA_W-1:0]           ld_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_reg,
    output logic [DATA_W-1:0]           ra_out,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        masked
);
    localparam int RW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [STACK_DEPTH-1:0]          stk;
    logic                            mask;
    logic [DATA_W-1:0]               opa;
    logic [DATA_W-1:0]               opb;
    logic [DATA_W-1:0]               alu_res;
    logic                            writes_rd;
    logic                            wr_bc;
    logic                            cond_true;

    // Fetch operands and present readback/neighbour values.
    always_comb begin
        opa     = regs[ins_ra];
        opb     = regs[ins_rb];
        ra_out  = opa;
        rd_data = regs[rd_reg];
        masked  = mask;
    end

    // ALU result, condition evaluation and broadcast write enable.
    always_comb begin
        alu_res   = '0;
        writes_rd = 1'b1;
        case (ins_op)
            OP_ADD:  alu_res = opa + opb;
            OP_SUB:  alu_res = opa - opb;
            OP_AND:  alu_res = opa & opb;
            OP_OR:   alu_res = opa | opb;
            OP_XOR:  alu_res = opa ^ opb;
            OP_LDI:  alu_res = ins_imm;
            OP_ADDI: alu_res = opa + ins_imm;
            OP_SHL:  alu_res = hi_in;
            OP_SHR:  alu_res = lo_in;
            default: writes_rd = 1'b0;
        endcase
        cond_true = (ins_op == OP_IFEQ) ? (opa == opb) : (opa < opb);
        wr_bc     = ins_valid && !mask && writes_rd;
    end

    // Register file: load port has priority over the broadcast write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (ld_hit && ld_reg == RW'(k)) begin
                    regs[k] <= ld_data;
                end else if (wr_bc && ins_rd == RW'(k)) begin
                    regs[k] <= alu_res;
                end
            end
        end
    end

    // Mask bit: set on failed IF, invert on ELSE within saved set, restore on ENDIF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b0;
        end else if (push) begin
            mask <= mask | !cond_true;
        end else if (flip) begin
            mask <= stk[0] | !mask;
        end else if (pop) begin
            mask <= stk[0];
        end
    end

    // Mask stack, entry 0 is the innermost saved mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk <= '0;
        end else if (push) begin
            for (int k = STACK_DEPTH - 1; k > 0; k--) begin
                stk[k] <= stk[k-1];
            end
            stk[0] <= mask;
        end else if (pop) begin
            for (int k = 0; k < STACK_DEPTH - 1; k++) begin
                stk[k] <= stk[k+1];
            end
            stk[STACK_DEPTH-1] <= 1'b0;
        end
    end

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && mask && !ld_hit) |=> $stable(regs)); // R4
    AST_IF_KEEPS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && mask) |=> mask); // R5
    AST_ELSE_OUTSIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && stk[0]) |=> mask); // R6
endmodule

// File: rtl/simd_lane_array.sv
// Module: simd_lane_array (top)
// Row of NUM_PE lockstep elements sharing one broadcast instruction, with
// nearest-neighbour wiring, load/readback access and an "any active" flag.
// Assumes at most one instruction per cycle from an external control unit.
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int NUM_PE      = 8,
    parameter int DATA_W      = 16,
    parameter int NUM_REGS    = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_valid,
    input  logic [3:0]                  ins_op,
    input  logic [$clog2(NUM_REGS)-1:0] ins_rd,
    input  logic [$clog2(NUM_REGS)-1:0] ins_ra,
    input  logic [$clog2(NUM_REGS)-1:0] ins_rb,
    input  logic [DATA_W-1:0]           ins_imm,
    input  logic                        ld_en,
    input  logic [$clog2(NUM_PE)-1:0]   ld_pe,
    input  logic [$clog2(NUM_REGS)-1:0] ld_reg,
    input  logic [DATA_W-1:0]           ld_data,
    input  logic [$clog2(NUM_PE)-1:0]   rd_pe,
    input  logic [$clog2(NUM_REGS)-1:0] rd_reg,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        any_active
);
    localparam int PW = $clog2(NUM_PE);

    logic                           push;
    logic                           flip;
    logic                           pop;
    logic [NUM_PE-1:0][DATA_W-1:0]  ra_vals;
    logic [NUM_PE-1:0][DATA_W-1:0]  rd_vals;
    logic [NUM_PE-1:0]              masks;

    simd_mask_ctl #(.STACK_DEPTH(STACK_DEPTH)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_op    (ins_op),
        .push      (push),
        .flip      (flip),
        .pop       (pop)
    );

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        logic [DATA_W-1:0] hi_nb;
        logic [DATA_W-1:0] lo_nb;
        logic              hit;

        if (g == NUM_PE - 1) begin : g_hi_end
            assign hi_nb = '0;
        end else begin : g_hi_mid
            assign hi_nb = ra_vals[g+1];
        end
        if (g == 0) begin : g_lo_end
            assign lo_nb = '0;
        end else begin : g_lo_mid
            assign lo_nb = ra_vals[g-1];
        end
        assign hit = ld_en && (ld_pe == PW'(g));

        simd_pe #(
            .DATA_W      (DATA_W),
            .NUM_REGS    (NUM_REGS),
            .STACK_DEPTH (STACK_DEPTH)
        ) pe_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ins_valid (ins_valid),
            .ins_op    (ins_op),
            .ins_rd    (ins_rd),
            .ins_ra    (ins_ra),
            .ins_rb    (ins_rb),
            .ins_imm   (ins_imm),
            .push      (push),
            .flip      (flip),
            .pop       (pop),
            .hi_in     (hi_nb),
            .lo_in     (lo_nb),
            .ld_hit    (hit),
            .ld_reg    (ld_reg),
            .ld_data   (ld_data),
            .rd_reg    (rd_reg),
            .ra_out    (ra_vals[g]),
            .rd_data   (rd_vals[g]),
            .masked    (masks[g])
        );
    end

    // Readback mux and global activity flag.
    always_comb begin
        rd_data    = (int'(rd_pe) < NUM_PE) ? rd_vals[rd_pe] : '0;
        any_active = ~&masks;
    end

    AST_SHIFT_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_op == OP_SHR && !masks[0] && !ld_en && rd_reg == ins_rd && rd_pe == '0)
        |=> rd_data == '0); // R10
endmodule

// File: tb/simd_lane_array_tb.sv
`timescale 1ns/1ps
// Bench: simd_lane_array_tb_top
// Behavioural reference model of the element array compared against the DUT.
module simd_lane_array_tb_top;
    import simd_pkg::*;

    localparam int NPE = 8;
    localparam int DW  = 16;
    localparam int NR  = 4;
    localparam int SD  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [3:0]    ins_op = '0;
    logic [1:0]    ins_rd = '0, ins_ra = '0, ins_rb = '0;
    logic [DW-1:0] ins_imm = '0;
    logic          ld_en = 1'b0;
    logic [2:0]    ld_pe = '0;
    logic [1:0]    ld_reg = '0;
    logic [DW-1:0] ld_data = '0;
    logic [2:0]    rd_pe = '0;
    logic [1:0]    rd_reg = '0;
    logic [DW-1:0] rd_data;
    logic          any_active;

    int tests = 0;
    int fails = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    // Reference state
    logic [DW-1:0] m_regs [NPE][NR];
    bit            m_mask [NPE];
    bit            m_stk  [NPE][SD];
    int            m_depth;

    always #2.5 clk = ~clk;

    simd_lane_array #(.NUM_PE(NPE), .DATA_W(DW), .NUM_REGS(NR), .STACK_DEPTH(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_rd(ins_rd), .ins_ra(ins_ra), .ins_rb(ins_rb), .ins_imm(ins_imm),
        .ld_en(ld_en), .ld_pe(ld_pe), .ld_reg(ld_reg), .ld_data(ld_data),
        .rd_pe(rd_pe), .rd_reg(rd_reg), .rd_data(rd_data), .any_active(any_active)
    );

    function automatic bit model_any();
        for (int p = 0; p < NPE; p++) if (!m_mask[p]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NPE; p++) begin
            m_mask[p] = 1'b0;
            for (int r = 0; r < NR; r++) m_regs[p][r] = '0;
            for (int s = 0; s < SD; s++) m_stk[p][s] = 1'b0;
        end
        m_depth = 0;
    endtask

    // Apply one cycle of broadcast instruction plus load to the model.
    task automatic model_step(input bit v, input int op, input int rd, input int ra,
                              input int rb, input logic [DW-1:0] imm, input bit le,
                              input int lp, input int lr, input logic [DW-1:0] ldv);
        logic [DW-1:0] old [NPE][NR];
        for (int p = 0; p < NPE; p++)
            for (int r = 0; r < NR; r++) old[p][r] = m_regs[p][r];
        if (v) begin
            for (int p = 0; p < NPE; p++) begin
                logic [DW-1:0] a, b, res;
                bit wr;
                a = old[p][ra]; b = old[p][rb]; wr = 1'b1; res = '0;
                case (op)
                    1: res = a + b;
                    2: res = a - b;
                    3: res = a & b;
                    4: res = a | b;
                    5: res = a ^ b;
                    6: res = imm;
                    7: res = a + imm;
                    8: res = (p == NPE - 1) ? '0 : old[p+1][ra];
                    9: res = (p == 0) ? '0 : old[p-1][ra];
                    default: wr = 1'b0;
                endcase
                if (wr && !m_mask[p]) m_regs[p][rd] = res;
            end
            if ((op == 10 || op == 11) && m_depth < SD) begin
                for (int p = 0; p < NPE; p++) begin
                    bit c;
                    c = (op == 10) ? (old[p][ra] == old[p][rb]) : (old[p][ra] < old[p][rb]);
                    m_stk[p][m_depth] = m_mask[p];
                    if (!m_mask[p] && !c) m_mask[p] = 1'b1;
                end
                m_depth++;
            end else if (op == 12 && m_depth > 0) begin
                for (int p = 0; p < NPE; p++)
                    if (!m_stk[p][m_depth-1]) m_mask[p] = !m_mask[p];
            end else if (op == 13 && m_depth > 0) begin
                m_depth--;
                for (int p = 0; p < NPE; p++) m_mask[p] = m_stk[p][m_depth];
            end
        end
        if (le) m_regs[lp][lr] = ldv;
    endtask

    // One clock with an instruction and/or a load; model updated after the edge.
    task automatic cyc(input bit v, input int op, input int rd, input int ra, input int rb,
                       input int imm, input bit le = 0, input int lp = 0, input int lr = 0,
                       input int ldv = 0);
        @(negedge clk);
        ins_valid = v; ins_op = 4'(op); ins_rd = 2'(rd); ins_ra = 2'(ra); ins_rb = 2'(rb);
        ins_imm = DW'(imm); ld_en = le; ld_pe = 3'(lp); ld_reg = 2'(lr); ld_data = DW'(ldv);
        @(posedge clk);
        #0.5;
        model_step(v, op, rd, ra, rb, DW'(imm), le, lp, lr, DW'(ldv));
        ins_valid = 1'b0; ld_en = 1'b0;
    endtask

    task automatic ins(input int op, input int rd, input int ra, input int rb, input int imm);
        cyc(1'b1, op, rd, ra, rb, imm);
    endtask

    task automatic load(input int p, input int r, input int v);
        cyc(1'b0, 0, 0, 0, 0, 0, 1'b1, p, r, v);
    endtask

    task automatic check_reg(input int p, input int r, input logic [DW-1:0] exp, input string tag);
        rd_pe = 3'(p); rd_reg = 2'(r);
        #0.5;
        tests++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s pe%0d r%0d actual=%h expected=%h", tag, p, r, rd_data, exp);
        end
    endtask

    task automatic check_any(input bit exp, input string tag);
        #0.2;
        tests++;
        if (any_active !== exp) begin
            fails++;
            $display("FAIL %s any_active actual=%b expected=%b", tag, any_active, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int p = 0; p < NPE; p++)
            for (int r = 0; r < NR; r++) check_reg(p, r, m_regs[p][r], tag);
    endtask

    // Every-clock comparison of the activity flag against the model (R9).
    always @(negedge clk) begin
        if (model_on && !finished) begin
            tests++;
            if (any_active !== model_any()) begin
                fails++;
                $display("FAIL R9 clock compare any_active actual=%b expected=%b",
                         any_active, model_any());
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        model_on = 1'b1;
        // R1 reset state
        check_reg(0, 0, 16'h0000, "R1 reset");
        check_reg(7, 3, 16'h0000, "R1 reset");
        check_any(1'b1, "R1 reset");

        // R2 loads: r0 = 3*i, r1 = 10
        for (int p = 0; p < NPE; p++) begin
            load(p, 0, 3 * p);
            load(p, 1, 10);
        end
        check_reg(6, 0, 16'd18, "R2 load readback");

        // R3 data ops
        ins(1, 2, 0, 1, 0);                 // r2 = r0 + r1
        check_reg(5, 2, 16'd25, "R3 add");
        ins(2, 3, 1, 0, 0);                 // r3 = r1 - r0
        check_reg(7, 3, 16'hFFF5, "R3 sub wrap");
        ins(5, 3, 3, 3, 0);                 // r3 = 0
        ins(7, 3, 1, 0, 16'hFFFF);          // r3 = r1 - 1
        check_reg(2, 3, 16'd9, "R3 addi wrap");

        // R5/R6/R7 simple if-then-else: r0 < r1 true for pe0..3
        ins(11, 0, 0, 1, 0);
        check_any(1'b1, "R5 if");
        ins(6, 3, 0, 0, 100);
        check_reg(1, 3, 16'd100, "R5 then active");
        check_reg(6, 3, 16'd9, "R4 then masked hold");
        ins(12, 0, 0, 0, 0);
        ins(6, 3, 0, 0, 200);
        check_reg(6, 3, 16'd200, "R6 else active");
        check_reg(1, 3, 16'd100, "R6 else masked");
        ins(13, 0, 0, 0, 0);

        // Nested conditional
        ins(11, 0, 0, 1, 0);                // pe0..3
        ins(6, 3, 0, 0, 6);
        ins(10, 0, 0, 3, 0);                // r0 == 6: pe2 only
        ins(7, 1, 1, 0, 1);
        check_reg(2, 1, 16'd11, "R5 nested then");
        check_reg(0, 1, 16'd10, "R5 nested masked");
        ins(12, 0, 0, 0, 0);                // pe0,1,3
        ins(7, 1, 1, 0, 5);
        check_reg(0, 1, 16'd15, "R6 nested else");
        check_reg(2, 1, 16'd11, "R6 nested else hold");
        check_reg(5, 1, 16'd10, "R6 outer masked hold");
        ins(13, 0, 0, 0, 0);
        ins(6, 2, 0, 0, 7);
        check_reg(3, 2, 16'd7, "R7 restore inner");
        check_reg(5, 2, 16'd25, "R7 restore outer masked");
        ins(13, 0, 0, 0, 0);
        ins(6, 2, 0, 0, 8);
        check_reg(5, 2, 16'd8, "R7 restore all");

        // R9 empty branch: r0 == r1 nowhere
        ins(10, 0, 0, 1, 0);
        check_any(1'b0, "R9 empty then");
        ins(12, 0, 0, 0, 0);
        check_any(1'b1, "R9 else all");
        ins(13, 0, 0, 0, 0);

        // R10 shifts
        ins(8, 3, 0, 0, 0);
        check_reg(0, 3, 16'd3, "R10 shl");
        check_reg(7, 3, 16'd0, "R10 shl end zero");
        ins(9, 2, 0, 0, 0);
        check_reg(0, 2, 16'd0, "R10 shr end zero");
        check_reg(7, 2, 16'd18, "R10 shr");

        // Masked shift and load under mask: active pe0..3
        ins(11, 0, 0, 1, 0);
        ins(9, 1, 0, 0, 0);
        check_reg(3, 1, 16'd6, "R10 masked shift active");
        check_reg(4, 1, 16'd10, "R4 masked shift hold");
        load(6, 1, 16'h1234);
        check_reg(6, 1, 16'h1234, "R2 load under mask");
        ins(13, 0, 0, 0, 0);

        // R2 load wins over broadcast to the same register
        cyc(1'b1, 6, 0, 0, 0, 5, 1'b1, 4, 0, 16'h0055);
        check_reg(4, 0, 16'h0055, "R2 load priority");
        check_reg(3, 0, 16'd5, "R2 broadcast others");

        // R8 nesting limit
        for (int k = 0; k < 4; k++) ins(10, 0, 0, 0, 0);
        ins(11, 0, 0, 0, 0);                // would mask all, ignored
        check_any(1'b1, "R8 fifth if ignored");
        for (int k = 0; k < 4; k++) ins(13, 0, 0, 0, 0);
        ins(13, 0, 0, 0, 0);
        ins(12, 0, 0, 0, 0);                // else with nothing open
        check_any(1'b1, "R8 empty else ignored");
        sweep("R3 model directed");

        // Pseudo-random stream against the model
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(15, 0));
            if ($urandom_range(3, 0) == 0)
                cyc(1'b1, op, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                    int'($urandom_range(3, 0)), int'($urandom_range(65535, 0)), 1'b1,
                    int'($urandom_range(7, 0)), int'($urandom_range(3, 0)),
                    int'($urandom_range(65535, 0)));
            else
                ins(op, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                    int'($urandom_range(3, 0)), int'($urandom_range(15, 0)));
        end
        sweep("R3 R4 R10 model random");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #0.5;
        model_reset();
        rst_n = 1'b1;
        check_reg(3, 2, 16'h0000, "R1 reset again");
        check_any(1'b1, "R1 reset again");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule